// File: doc/BRIEF.md
# Cache maintenance range splitter

This block turns a byte-granular cache maintenance request into a series of hardware range commands. A request carries an operation (invalidate, clean or flush), a start address and an end address that is exclusive. The block emits commands that cover whole 32-byte lines. Each command gives a start address and an inclusive end address, and both are line aligned. No command spans more than 1024 bytes, and no command runs past the next 4 KB page boundary. Partial lines at the edges of an invalidate request are cleaned and invalidated one line at a time, so that neighbouring data in those lines is not lost.

A write-through override input tells the block that the cache never holds dirty data. When it is set, the block drops clean work. A clean request then produces nothing, and a flush request produces only invalidate commands. When a request is finished, the block raises a one-cycle completion pulse. The consumer treats this pulse as the point at which a memory barrier is issued, and it arrives even when the request produced no command. Requests are accepted only while the block is idle. Commands leave on a valid/ready handshake.

Top module: `range_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, and `cmd_valid` and `done` are 0.
- R2: A request is taken only when `req_ready` is 1. `req_ready` is 1 only in the idle state, so it stays 0 from acceptance until the completion pulse, and it is never 1 while `cmd_valid` is 1.
- R3: For request op 1 (clean) and ops 2 or 3 (flush), the start is rounded down and the end is rounded up to a 32-byte boundary. Every range command then has a line-aligned start and a line-aligned inclusive end. A request whose rounded end does not exceed its rounded start emits no range command.
- R4: No command covers more than 1024 bytes, so the inclusive end minus the start is at most 992.
- R5: A command's start and inclusive end lie in the same 4 KB page. A chunk ends at the earliest of three points: the request end, start+1024, and (start OR 0xFFF)+1.
- R6: Chunks tile the request without gaps or overlap. Each command's inclusive end equals its chunk end minus 32, and the next chunk starts at that chunk end.
- R7: Command op codes are 0 = clean range, 1 = invalidate range, 2 = clean-and-invalidate one line; a single-line command has start equal to end. For request op 0 (invalidate) with a start that is not line aligned, the first command is op 2 on the line that holds the start, and the start then moves to the next line boundary.
- R8: For invalidate, if after that step the start is still below the end and the end is not line aligned, the next command is op 2 on the line that holds the end. The end is then rounded down, and op 1 range commands follow for the whole lines.
- R9: For flush with the override clear, each chunk gives an op 0 command and then an op 1 command with the same addresses.
- R10: With `wt_override` set when the request is accepted, a clean request emits no command, and a flush emits only op 1 commands, one per chunk.
- R11: `done` is high for exactly one cycle after the last command of each request, including requests that emit no command, and never while `cmd_valid` is 1.
- R12: While `cmd_valid` is 1 and `cmd_ready` is 0, the command op, start and end hold their values and `cmd_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | Exclusive end address of the request |
| wt_override | input | 1 | Write-through override, sampled at acceptance |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_op | output | 2 | 0 clean range, 1 invalidate range, 2 clean-and-invalidate line |
| cmd_start | output | ADDR_W | Line-aligned first address of the command |
| cmd_end | output | ADDR_W | Line-aligned inclusive last line address |
| done | output | 1 | One-cycle completion (barrier) pulse |

## Verification
The main sweep walks request starts at odd strides across a page boundary. It combines them with lengths of zero, under one line, exactly one line, just over a line, exactly one chunk, just over a chunk, and several kilobytes, and it runs every operation with the override both clear and set. Lengths of zero and under one line separate head-only and empty invalidates from those that emit a tail line. Lengths around 1024 bytes and starts near 0x1000 show whether the size cap or the page boundary ends a chunk. The override setting separates flush that interleaves clean and invalidate commands from flush that emits invalidate only. A pseudo-random ready pattern stalls the output, which tests whether commands hold steady and whether the completion pulse still follows the last handshake.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

  typedef enum logic [1:0] {
    CMD_CLEAN   = 2'd0,
    CMD_INV     = 2'd1,
    CMD_LINE_CI = 2'd2
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_HEAD  = 3'd2,
    ST_TAIL  = 3'd3,
    ST_PASS1 = 3'd4,
    ST_PASS2 = 3'd5,
    ST_DONE  = 3'd6
  } st_e;

  localparam logic [1:0] REQ_INV   = 2'd0;
  localparam logic [1:0] REQ_CLEAN = 2'd1;

endpackage

// File: rtl/rsplit_rst_sync.sv
module rsplit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rsplit_norm.sv
// Shapes a request at acceptance: invalidate keeps raw bytes (edges are
// handled line by line later), clean and flush are widened to whole lines.
module rsplit_norm #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] stop_addr,
  output logic [ADDR_W-1:0] cur0,
  output logic [ADDR_W-1:0] lim0,
  output logic              head0
);
  localparam int LW = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LOW  = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] MASK = ~LOW;

  logic is_inv;

  always_comb begin
    is_inv = (op == rsplit_pkg::REQ_INV);
    if (is_inv) begin
      cur0  = start_addr;
      lim0  = stop_addr;
      head0 = |start_addr[LW-1:0];
    end else begin
      cur0  = start_addr & MASK;
      lim0  = (stop_addr + LOW) & MASK;
      head0 = 1'b0;
    end
  end
endmodule

// File: rtl/rsplit_chunk_calc.sv
// End (exclusive) of the chunk starting at cur: the earliest of the
// request limit, the size cap and the next page boundary.
module rsplit_chunk_calc #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] lim,
  output logic [ADDR_W-1:0] chunk_end
);
  localparam int AX = ADDR_W + 1;

  logic [AX-1:0] cap_x, page_x, pick_x;

  always_comb begin
    cap_x  = {1'b0, cur} + AX'(CHUNK_BYTES);
    page_x = {1'b0, cur | ADDR_W'(PAGE_BYTES - 1)} + AX'(1);
    pick_x = {1'b0, lim};
    if (pick_x > cap_x)  pick_x = cap_x;
    if (pick_x > page_x) pick_x = page_x;
    chunk_end = pick_x[ADDR_W-1:0];
  end
endmodule

// File: rtl/range_splitter.sv
module range_splitter
  import rsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_start,
  output logic [ADDR_W-1:0] cmd_end,
  output logic              done
);
  localparam int LW = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_LOW  = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~LINE_LOW;

  logic rst_core_n;

  st_e               state_q, state_d;
  logic [1:0]        op_q;
  logic              wt_q;
  logic [ADDR_W-1:0] cur_q, cur_d, lim_q, lim_d;
  logic              head_q, head_d;
  logic              req_en, cur_en, lim_en, head_en;

  logic [ADDR_W-1:0] norm_cur, norm_lim, chunk_end;
  logic              norm_head;
  logic              fire, more, tail_need, body_need;
  logic              is_inv_q, is_clean_q, is_flush_q;

  rsplit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rsplit_norm #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_norm (
    .op         (req_op),
    .start_addr (req_start),
    .stop_addr  (req_end),
    .cur0       (norm_cur),
    .lim0       (norm_lim),
    .head0      (norm_head)
  );

  rsplit_chunk_calc #(
    .ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_chunk (
    .cur       (cur_q),
    .lim       (lim_q),
    .chunk_end (chunk_end)
  );

  // ---------------- decode of captured request ----------------
  always_comb begin
    is_inv_q   = (op_q == REQ_INV);
    is_clean_q = (op_q == REQ_CLEAN);
    is_flush_q = op_q[1];
    more       = (cur_q < lim_q);
    tail_need  = is_inv_q && (|lim_q[LW-1:0]) && more;
    body_need  = more && !(is_clean_q && wt_q);
  end

  // ---------------- command outputs ----------------
  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = CMD_CLEAN;
    cmd_start = '0;
    cmd_end   = '0;
    unique case (state_q)
      ST_HEAD: begin
        cmd_valid = 1'b1;
        cmd_op    = CMD_LINE_CI;
        cmd_start = cur_q & LINE_MASK;
        cmd_end   = cur_q & LINE_MASK;
      end
      ST_TAIL: begin
        cmd_valid = 1'b1;
        cmd_op    = CMD_LINE_CI;
        cmd_start = lim_q & LINE_MASK;
        cmd_end   = lim_q & LINE_MASK;
      end
      ST_PASS1: begin
        cmd_valid = 1'b1;
        if (is_clean_q)               cmd_op = CMD_CLEAN;
        else if (is_inv_q || wt_q)    cmd_op = CMD_INV;
        else                          cmd_op = CMD_CLEAN;
        cmd_start = cur_q;
        cmd_end   = chunk_end - ADDR_W'(LINE_BYTES);
      end
      ST_PASS2: begin
        cmd_valid = 1'b1;
        cmd_op    = CMD_INV;
        cmd_start = cur_q;
        cmd_end   = chunk_end - ADDR_W'(LINE_BYTES);
      end
      default: ;
    endcase
  end

  assign fire      = cmd_valid && cmd_ready;
  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    req_en  = 1'b0;
    cur_en  = 1'b0;
    lim_en  = 1'b0;
    head_en = 1'b0;
    cur_d   = cur_q;
    lim_d   = lim_q;
    head_d  = head_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_en  = 1'b1;
          cur_en  = 1'b1;
          lim_en  = 1'b1;
          head_en = 1'b1;
          cur_d   = norm_cur;
          lim_d   = norm_lim;
          head_d  = norm_head;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (head_q)         state_d = ST_HEAD;
        else if (tail_need) state_d = ST_TAIL;
        else if (body_need) state_d = ST_PASS1;
        else                state_d = ST_DONE;
      end
      ST_HEAD: begin
        if (fire) begin
          cur_en  = 1'b1;
          cur_d   = (cur_q | LINE_LOW) + ADDR_W'(1);
          head_en = 1'b1;
          head_d  = 1'b0;
          state_d = ST_EVAL;
        end
      end
      ST_TAIL: begin
        if (fire) begin
          lim_en  = 1'b1;
          lim_d   = lim_q & LINE_MASK;
          state_d = ST_EVAL;
        end
      end
      ST_PASS1: begin
        if (fire) begin
          if (is_flush_q && !wt_q) begin
            state_d = ST_PASS2;
          end else begin
            cur_en  = 1'b1;
            cur_d   = chunk_end;
            state_d = ST_EVAL;
          end
        end
      end
      ST_PASS2: begin
        if (fire) begin
          cur_en  = 1'b1;
          cur_d   = chunk_end;
          state_d = ST_EVAL;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      op_q <= '0;
      wt_q <= 1'b0;
    end else if (req_en) begin
      op_q <= req_op;
      wt_q <= wt_override;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cur_q <= '0;
    else if (cur_en)  cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  lim_q <= '0;
    else if (lim_en)  lim_q <= lim_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  head_q <= 1'b0;
    else if (head_en) head_q <= head_d;
  end
endmodule

// File: rtl/rsplit_checker.sv
module rsplit_checker #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_start,
  input logic [ADDR_W-1:0] cmd_end,
  input logic              done,
  input logic              wt_q
);
  localparam int LW = $clog2(LINE_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] MAX_SPAN = ADDR_W'(CHUNK_BYTES - LINE_BYTES);

  assert_idle_no_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[LW-1:0] == '0) && (cmd_end[LW-1:0] == '0));

  assert_span_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_end >= cmd_start) && ((cmd_end - cmd_start) <= MAX_SPAN));

  assert_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[ADDR_W-1:PW] == cmd_end[ADDR_W-1:PW]));

  assert_line_cmd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> (cmd_start == cmd_end));

  assert_op_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'd3));

  assert_no_clean_wt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wt_q) |-> (cmd_op != 2'd0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_start) && $stable(cmd_end)));
endmodule

bind range_splitter rsplit_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_start (cmd_start),
  .cmd_end   (cmd_end),
  .done      (done),
  .wt_q      (wt_q)
);

// File: tb/tb_range_splitter.sv
module tb_range_splitter;
  localparam int AW = 32;

  logic          clk, rst_n;
  logic          req_valid, req_ready, wt_override;
  logic [1:0]    req_op;
  logic [AW-1:0] req_start, req_end;
  logic          cmd_valid, cmd_ready, done;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_start, cmd_end;

  range_splitter dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] lfsr;

  int              exp_n;
  int              exp_op [0:63];
  longint unsigned exp_s  [0:63];
  longint unsigned exp_e  [0:63];

  task automatic push(input int op, input longint unsigned a, input longint unsigned b);
    if (exp_n < 64) begin
      exp_op[exp_n] = op; exp_s[exp_n] = a; exp_e[exp_n] = b;
    end
    exp_n++;
  endtask

  function automatic longint unsigned chunk_lim(input longint unsigned s, input longint unsigned e);
    longint unsigned r, pg;
    r = e;
    if (r > s + 1024) r = s + 1024;
    pg = (s | 64'hFFF) + 1;
    if (r > pg) r = pg;
    return r;
  endfunction

  // Expected command list from the requirements (R3..R10).
  task automatic build(input int op, input longint unsigned s0, input longint unsigned e0, input bit wt);
    longint unsigned s, e, re;
    s = s0; e = e0; exp_n = 0;
    if (op == 0) begin
      if ((s & 31) != 0) begin
        push(2, s & ~64'd31, s & ~64'd31);
        s = (s | 31) + 1;
      end
      if (s < e && (e & 31) != 0) begin
        push(2, e & ~64'd31, e & ~64'd31);
        e = e & ~64'd31;
      end
      while (s < e) begin
        re = chunk_lim(s, e);
        push(1, s, re - 32);
        s = re;
      end
    end else begin
      s = s & ~64'd31;
      e = (e + 31) & ~64'd31;
      if (!(op == 1 && wt)) begin
        while (s < e) begin
          re = chunk_lim(s, e);
          if (op == 1) push(0, s, re - 32);
          else begin
            if (!wt) push(0, s, re - 32);
            push(1, s, re - 32);
          end
          s = re;
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned got, input longint unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, expv);
    end
  endtask

  task automatic run_req(input string tag, input int op, input longint unsigned s,
                         input longint unsigned e, input bit wt);
    int got, cyc;
    bit seen_done, stall, stable_ok, busy_ok, cmp_ok;
    logic [1:0] h_op; logic [AW-1:0] h_s, h_e;
    build(op, s, e, wt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_start = s[AW-1:0];
    req_end = e[AW-1:0]; wt_override = wt;
    check(req_ready === 1'b1, "R2", "ready before request", {63'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; cyc = 0; seen_done = 0; stall = 0; stable_ok = 1; busy_ok = 1; cmp_ok = 1;
    h_op = '0; h_s = '0; h_e = '0;
    while (!seen_done && cyc < 3000) begin
      if (req_ready !== 1'b0) busy_ok = 0;
      if (done === 1'b1) begin
        seen_done = 1;
        if (cmd_valid !== 1'b0) cmp_ok = 0;
      end else begin
        if (stall && (cmd_valid !== 1'b1 || cmd_op !== h_op || cmd_start !== h_s || cmd_end !== h_e))
          stable_ok = 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready = lfsr[0] | lfsr[3];
        if (cmd_valid === 1'b1 && cmd_ready) begin
          if (got >= exp_n) begin
            check(0, tag, "extra command start", {32'd0, cmd_start}, 0);
          end else begin
            check(cmd_op == exp_op[got][1:0] && cmd_start == exp_s[got][AW-1:0] &&
                  cmd_end == exp_e[got][AW-1:0], tag, $sformatf("cmd %0d op/start/end", got),
                  {30'd0, cmd_op, cmd_start} , {exp_op[got][1:0], exp_s[got][AW-1:0]});
            if (cmd_end != exp_e[got][AW-1:0])
              $display("      %s cmd %0d end actual %h expected %h", tag, got, cmd_end, exp_e[got]);
          end
          got++;
        end
        stall = (cmd_valid === 1'b1) && !cmd_ready;
        h_op = cmd_op; h_s = cmd_start; h_e = cmd_end;
      end
      @(negedge clk);
      cyc++;
    end
    check(seen_done, "R11", $sformatf("%s completion pulse seen", tag), {63'd0, seen_done}, 1);
    check(cmp_ok, "R11", "no command during completion", 0, 0);
    check(got == exp_n, tag, "command count", got, exp_n);
    check(stable_ok, "R12", "command held during stall", {63'd0, stable_ok}, 1);
    check(busy_ok, "R2", "not ready while busy", {63'd0, busy_ok}, 1);
    check(done === 1'b0 && req_ready === 1'b1, "R11", "single-cycle completion",
          {62'd0, done, req_ready}, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [12];
    lens = '{0, 1, 5, 31, 32, 33, 100, 1024, 1025, 2000, 3000, 5000};
    lfsr = 16'hACE1;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_start = '0; req_end = '0;
    wt_override = 1'b0; cmd_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1", "reset outputs",
          {61'd0, req_ready, cmd_valid, done}, 4);

    // directed corners
    run_req("R4",  1, 64'h0,    64'h2000, 0);
    run_req("R5",  1, 64'h0F00, 64'h1300, 0);
    run_req("R6",  0, 64'h2000, 64'h2040, 0);
    run_req("R7",  0, 64'h1005, 64'h1010, 0);
    run_req("R8",  0, 64'h1005, 64'h1047, 0);
    run_req("R11", 1, 64'h40,   64'h40,   0);
    run_req("R11", 0, 64'h80,   64'h80,   0);
    run_req("R10", 1, 64'h0,    64'h100,  1);
    run_req("R10", 2, 64'h0FE0, 64'h1040, 1);
    run_req("R9",  2, 64'h0FE0, 64'h1040, 0);
    run_req("R3",  3, 64'h0FF3, 64'h1001, 0);

    // sweep across a page boundary
    for (int i = 0; i < 16; i++) begin
      for (int l = 0; l < 12; l++) begin
        for (int op = 0; op < 3; op++) begin
          for (int w = 0; w < 2; w++) begin
            longint unsigned st;
            string tg;
            st = 64'h0F00 + longint'(i) * 37;
            if (op == 0)       tg = "R7";
            else if (w == 1)   tg = "R10";
            else if (op == 1)  tg = "R3";
            else               tg = "R9";
            run_req(tg, op, st, st + longint'(lens[l]), w[0]);
          end
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule